// File: doc/BRIEF.md
# Dual-Channel Power-Good / Reset Supervisor

This block drives a single open-drain, active-high supervisory pin from the state of two regulator channels. For each channel it takes four status inputs: a comparator flag that rises once the output passes 90% of its nominal coarse setting, an on flag, an overcurrent flag and a pulse that marks each step of a dynamic output-voltage change. A two-bit selector picks which channels are watched. A mode bit picks between two behaviours. In power-good mode the pin is released as soon as the watched channels are good. In reset mode the pin is released only after the watched channels have held good for a long, programmable hold time.

Each channel has its own qualifier. A short dip below the threshold is filtered out, and a channel only loses good status after a programmable run of consecutive low comparator samples. The comparator is ignored for a programmable window after each dynamic-voltage step. An off or overcurrent channel loses good status at once. All time windows are parameters counted in clock cycles. The block's only output is the pull-low enable for the pin driver: 1 pulls the pin low, 0 releases it.

Top module: `pwrsup_top`

## Requirements
- R1: The selector `mon_sel` picks the watched channels as follows: 2'b00 watches both channels, 2'b01 watches channel 1 only, 2'b10 watches channel 0 only. A channel that is not watched has no effect on the pin.
- R2: A channel becomes good one clock after it is on, free of overcurrent and above threshold.
- R3: A watched channel that is off or in overcurrent makes `pin_pull_low` go to 1 within two clocks, in either mode.
- R4: In power-good mode (`rst_mode`=0), `pin_pull_low` goes to 0 one clock after all watched channels are good.
- R5: In reset mode (`rst_mode`=1), `pin_pull_low` goes to 0 only after all watched channels have been good for RST_DLY_CYC consecutive clocks.
- R6: If any watched channel loses good status during the reset hold time, the hold count restarts from zero.
- R7: A channel that is on and free of overcurrent loses good status only after its comparator has been low for DEG_CYC consecutive clocks. A shorter dip has no effect on the pin.
- R8: For BLANK_CYC clocks after a `dvs_step` pulse on a channel, a low comparator on that channel is ignored.
- R9: A change of `mon_sel` or `rst_mode` takes effect on the next clock. In reset mode, such a change withdraws the release and restarts the hold count.
- R10: After reset, `pin_pull_low` is 1 unless `mon_sel` is 2'b11.
- R11: With `mon_sel` equal to 2'b11, `pin_pull_low` is 0 one clock later and stays 0, whatever the channel inputs and the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_above | input | 2 | Per-channel comparator flag: output above 90% of nominal |
| ch_on | input | 2 | Per-channel on status |
| ch_oc | input | 2 | Per-channel overcurrent status |
| dvs_step | input | 2 | Per-channel one-clock pulse at each dynamic-voltage step |
| mon_sel | input | 2 | Channel watch selector (00 both, 01 ch1, 10 ch0, 11 none) |
| rst_mode | input | 1 | 0 = power-good mode, 1 = reset mode with hold time |
| pin_pull_low | output | 1 | 1 pulls the open-drain pin low, 0 releases it |

## Verification
The assertions assume that all channel inputs are synchronous to `clk` and that `mon_sel` and `rst_mode` are stable across the windows that the hold-time and off-channel properties span. The release property keys its own run counter to any settings change, so it stays valid when the settings move. The stimulus changes inputs only on the falling edge and holds the settings steady through each scenario. The `dvs_step` pulses last one clock. The bench uses short windows (deglitch 8, blanking 20, hold 50) so that every boundary can be reached in a few hundred cycles.

// File: rtl/pwrsup_pkg.sv
package pwrsup_pkg;

    typedef enum logic [1:0] {
        MON_BOTH = 2'b00,
        MON_CH1  = 2'b01,
        MON_CH0  = 2'b10,
        MON_NONE = 2'b11
    } mon_sel_e;

    typedef struct packed {
        logic on;
        logic oc;
        logic above;
        logic step;
    } chan_in_t;

    typedef struct packed {
        logic     rst_mode;
        mon_sel_e sel;
    } sup_cfg_t;

    // bit i set when channel i is watched
    function automatic logic [1:0] mon_mask(mon_sel_e s);
        case (s)
            MON_BOTH: mon_mask = 2'b11;
            MON_CH1:  mon_mask = 2'b10;
            MON_CH0:  mon_mask = 2'b01;
            default:  mon_mask = 2'b00;
        endcase
    endfunction

    function automatic int cnt_w(int n);
        cnt_w = (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pwrsup_chan_qual.sv
module pwrsup_chan_qual
    import pwrsup_pkg::*;
#(
    parameter int DEG_CYC   = 8000,
    parameter int BLANK_CYC = 48000
) (
    input  logic     clk,
    input  logic     rst,
    input  chan_in_t cin,
    output logic     good
);
    localparam int DW = cnt_w(DEG_CYC);
    localparam int BW = cnt_w(BLANK_CYC);
    localparam logic [DW-1:0] DEG_LAST  = DW'(DEG_CYC - 1);
    localparam logic [BW-1:0] BLANK_LD  = BW'(BLANK_CYC);

    logic [DW-1:0] deg_cnt;
    logic [BW-1:0] blank_cnt;
    logic          blanking;

    assign blanking = (blank_cnt != '0);

    // blanking window after each dynamic-voltage step
    always_ff @(posedge clk) begin
        if (rst) begin
            blank_cnt <= '0;
        end else if (cin.step) begin
            blank_cnt <= BLANK_LD;
        end else if (blanking) begin
            blank_cnt <= blank_cnt - 1'b1;
        end
    end

    // good qualifier with falling deglitch
    always_ff @(posedge clk) begin
        if (rst) begin
            good    <= 1'b0;
            deg_cnt <= '0;
        end else if (!cin.on || cin.oc) begin
            good    <= 1'b0;
            deg_cnt <= '0;
        end else if (cin.above) begin
            good    <= 1'b1;
            deg_cnt <= '0;
        end else if (blanking || !good) begin
            deg_cnt <= '0;
        end else if (deg_cnt == DEG_LAST) begin
            good    <= 1'b0;
            deg_cnt <= '0;
        end else begin
            deg_cnt <= deg_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwrsup_release.sv
module pwrsup_release
    import pwrsup_pkg::*;
#(
    parameter int RST_DLY_CYC = 31250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] good_v,
    input  sup_cfg_t   cfg,
    output logic       released
);
    localparam int HW = cnt_w(RST_DLY_CYC);
    localparam logic [HW-1:0] HOLD_LAST = HW'(RST_DLY_CYC - 1);

    logic [HW-1:0] hold_cnt;
    sup_cfg_t      cfg_q;
    logic [1:0]    mask;
    logic          all_ok;
    logic          cfg_chg;

    assign mask    = mon_mask(cfg.sel);
    assign all_ok  = ((good_v | ~mask) == 2'b11);
    assign cfg_chg = (cfg != cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{rst_mode: 1'b0, sel: MON_BOTH};
        end else begin
            cfg_q <= cfg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            released <= 1'b0;
            hold_cnt <= '0;
        end else if (mask == 2'b00) begin
            released <= 1'b1;
            hold_cnt <= '0;
        end else if (!all_ok) begin
            released <= 1'b0;
            hold_cnt <= '0;
        end else if (!cfg.rst_mode) begin
            released <= 1'b1;
            hold_cnt <= '0;
        end else if (cfg_chg) begin
            released <= 1'b0;
            hold_cnt <= '0;
        end else if (!released) begin
            if (hold_cnt == HOLD_LAST) begin
                released <= 1'b1;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwrsup_top.sv
module pwrsup_top
    import pwrsup_pkg::*;
#(
    parameter int DEG_CYC     = 8000,
    parameter int BLANK_CYC   = 48000,
    parameter int RST_DLY_CYC = 31250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ch_above,
    input  logic [1:0] ch_on,
    input  logic [1:0] ch_oc,
    input  logic [1:0] dvs_step,
    input  logic [1:0] mon_sel,
    input  logic       rst_mode,
    output logic       pin_pull_low
);
    logic [1:0] good_v;
    logic       released;
    sup_cfg_t   cfg;

    assign cfg.rst_mode = rst_mode;
    assign cfg.sel      = mon_sel_e'(mon_sel);

    for (genvar i = 0; i < 2; i++) begin : g_ch
        chan_in_t cin;
        assign cin.on    = ch_on[i];
        assign cin.oc    = ch_oc[i];
        assign cin.above = ch_above[i];
        assign cin.step  = dvs_step[i];

        pwrsup_chan_qual #(
            .DEG_CYC  (DEG_CYC),
            .BLANK_CYC(BLANK_CYC)
        ) u_qual (
            .clk (clk),
            .rst (rst),
            .cin (cin),
            .good(good_v[i])
        );
    end

    pwrsup_release #(
        .RST_DLY_CYC(RST_DLY_CYC)
    ) u_rel (
        .clk     (clk),
        .rst     (rst),
        .good_v  (good_v),
        .cfg     (cfg),
        .released(released)
    );

    assign pin_pull_low = ~released;
endmodule

// File: rtl/pwrsup_chk.sv
module pwrsup_chk
    import pwrsup_pkg::*;
#(
    parameter int DEG_CYC     = 8000,
    parameter int RST_DLY_CYC = 31250000
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] ch_above,
    input logic [1:0] ch_on,
    input logic [1:0] ch_oc,
    input logic [1:0] mon_sel,
    input logic       rst_mode,
    input logic [1:0] good_v,
    input logic       pin_pull_low
);
    localparam int RW = cnt_w(RST_DLY_CYC);
    localparam int LW = cnt_w(DEG_CYC);

    logic [RW-1:0] ok_run;
    logic [LW-1:0] low_run0, low_run1;
    logic [2:0]    cfg_prev;
    logic          ok_now;
    logic [1:0]    msk;

    assign msk    = mon_mask(mon_sel_e'(mon_sel));
    assign ok_now = ((good_v | ~msk) == 2'b11);

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_run   <= '0;
            low_run0 <= '0;
            low_run1 <= '0;
            cfg_prev <= 3'b000;
        end else begin
            cfg_prev <= {rst_mode, mon_sel};
            if (!ok_now || !rst_mode || ({rst_mode, mon_sel} != cfg_prev))
                ok_run <= '0;
            else if (ok_run != RW'(RST_DLY_CYC))
                ok_run <= ok_run + 1'b1;
            if (ch_on[0] && !ch_oc[0] && !ch_above[0]) begin
                if (low_run0 != LW'(DEG_CYC)) low_run0 <= low_run0 + 1'b1;
            end else begin
                low_run0 <= '0;
            end
            if (ch_on[1] && !ch_oc[1] && !ch_above[1]) begin
                if (low_run1 != LW'(DEG_CYC)) low_run1 <= low_run1 + 1'b1;
            end else begin
                low_run1 <= '0;
            end
        end
    end

    // R11
    none_watched_high_chk: assert property (@(posedge clk) disable iff (rst)
        (mon_sel == 2'b11) |=> !pin_pull_low);

    // R3
    off_ch0_low_chk: assert property (@(posedge clk) disable iff (rst)
        ((mon_sel == 2'b00) && !ch_on[0]) ##1 (mon_sel == 2'b00) |=> pin_pull_low);

    // R3
    oc_ch1_low_chk: assert property (@(posedge clk) disable iff (rst)
        ((mon_sel == 2'b01) && ch_oc[1]) ##1 (mon_sel == 2'b01) |=> pin_pull_low);

    // R4
    pg_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst_mode && (mon_sel == 2'b00) && (good_v == 2'b11)) |=> !pin_pull_low);

    // R5
    hold_time_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(pin_pull_low) && $past(rst_mode) && ($past(mon_sel) != 2'b11))
        |-> (ok_run >= RW'(RST_DLY_CYC)));

    // R7
    deglitch0_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(good_v[0]) && $past(ch_on[0]) && !$past(ch_oc[0]))
        |-> (low_run0 >= LW'(DEG_CYC)));

    // R7
    deglitch1_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(good_v[1]) && $past(ch_on[1]) && !$past(ch_oc[1]))
        |-> (low_run1 >= LW'(DEG_CYC)));
endmodule

bind pwrsup_top pwrsup_chk #(
    .DEG_CYC    (DEG_CYC),
    .RST_DLY_CYC(RST_DLY_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ch_above    (ch_above),
    .ch_on       (ch_on),
    .ch_oc       (ch_oc),
    .mon_sel     (mon_sel),
    .rst_mode    (rst_mode),
    .good_v      (good_v),
    .pin_pull_low(pin_pull_low)
);

// File: tb/tb_pwrsup_top.sv
module tb_pwrsup_top;
    localparam int DEG   = 8;
    localparam int BLANK = 20;
    localparam int DLY   = 50;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] ch_above, ch_on, ch_oc, dvs_step, mon_sel;
    logic       rst_mode;
    logic       pin_pull_low;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pwrsup_top #(
        .DEG_CYC    (DEG),
        .BLANK_CYC  (BLANK),
        .RST_DLY_CYC(DLY)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .ch_above    (ch_above),
        .ch_on       (ch_on),
        .ch_oc       (ch_oc),
        .dvs_step    (dvs_step),
        .mon_sel     (mon_sel),
        .rst_mode    (rst_mode),
        .pin_pull_low(pin_pull_low)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pin(input logic exp, input string req);
        checks++;
        if (pin_pull_low !== exp) begin
            fails++;
            $display("FAIL %s: pin_pull_low=%b expected %b at %0t", req, pin_pull_low, exp, $time);
        end
    endtask

    task automatic all_good();
        ch_on = 2'b11; ch_oc = 2'b00; ch_above = 2'b11; dvs_step = 2'b00;
    endtask

    task automatic do_reset();
        rst = 1'b1; ch_on = 2'b00; ch_oc = 2'b00; ch_above = 2'b00;
        dvs_step = 2'b00; mon_sel = 2'b00; rst_mode = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic t_reset_state();
        do_reset();
        expect_pin(1'b1, "R10 reset state");
    endtask

    task automatic t_pg_basic();
        do_reset();
        all_good();
        cyc(2);
        expect_pin(1'b0, "R2 R4 power-good release");
        ch_on[0] = 1'b0;
        cyc(2);
        expect_pin(1'b1, "R3 ch0 off");
        ch_on[0] = 1'b1;
        cyc(2);
        expect_pin(1'b0, "R4 ch0 back");
        ch_oc[1] = 1'b1;
        cyc(2);
        expect_pin(1'b1, "R3 ch1 overcurrent");
        ch_oc[1] = 1'b0;
        cyc(2);
    endtask

    task automatic t_assign();
        do_reset();
        all_good();
        mon_sel = 2'b01;
        ch_on[0] = 1'b0;
        cyc(3);
        expect_pin(1'b0, "R1 ch1-only ignores ch0 off");
        mon_sel = 2'b10;
        cyc(2);
        expect_pin(1'b1, "R1 R9 ch0-only sees ch0 off");
        ch_on[0] = 1'b1; ch_oc[1] = 1'b1;
        cyc(3);
        expect_pin(1'b0, "R1 ch0-only ignores ch1 overcurrent");
        mon_sel = 2'b11; ch_on = 2'b00; rst_mode = 1'b1;
        cyc(2);
        expect_pin(1'b0, "R11 none watched");
        cyc(10);
        expect_pin(1'b0, "R11 none watched stays high");
    endtask

    task automatic t_deglitch();
        do_reset();
        all_good();
        cyc(3);
        ch_above[0] = 1'b0;
        cyc(4);
        ch_above[0] = 1'b1;
        cyc(3);
        expect_pin(1'b0, "R7 short dip ignored");
        ch_above[0] = 1'b0;
        cyc(DEG - 1);
        expect_pin(1'b0, "R7 still high before deglitch end");
        cyc(3);
        expect_pin(1'b1, "R7 long drop");
        ch_above[0] = 1'b1;
        cyc(2);
    endtask

    task automatic t_blank();
        do_reset();
        all_good();
        cyc(3);
        dvs_step[1] = 1'b1;
        cyc(1);
        dvs_step[1] = 1'b0;
        ch_above[1] = 1'b0;
        cyc(15);
        expect_pin(1'b0, "R8 low comparator blanked");
        ch_above[1] = 1'b1;
        cyc(30);
        ch_above[1] = 1'b0;
        cyc(DEG + 3);
        expect_pin(1'b1, "R8 blanking expired");
        ch_above[1] = 1'b1;
    endtask

    task automatic t_reset_mode();
        do_reset();
        rst_mode = 1'b1;
        cyc(2);
        all_good();
        cyc(DLY - 2);
        expect_pin(1'b1, "R5 held low during hold time");
        cyc(5);
        expect_pin(1'b0, "R5 released after hold time");
        ch_on[1] = 1'b0;
        cyc(2);
        expect_pin(1'b1, "R3 reset mode off drop");
        ch_on[1] = 1'b1;
        cyc(DLY / 2);
        ch_oc[0] = 1'b1;
        cyc(2);
        ch_oc[0] = 1'b0;
        cyc(DLY - 2);
        expect_pin(1'b1, "R6 hold restarted");
        cyc(5);
        expect_pin(1'b0, "R6 release after restart");
    endtask

    task automatic t_mode_change();
        do_reset();
        all_good();
        cyc(3);
        expect_pin(1'b0, "R4 pg released");
        rst_mode = 1'b1;
        cyc(2);
        expect_pin(1'b1, "R9 mode change withdraws release");
        cyc(DLY + 3);
        expect_pin(1'b0, "R9 release after new hold");
        rst_mode = 1'b0;
        cyc(2);
        expect_pin(1'b0, "R9 back to pg");
    endtask

    initial begin
        t_reset_state();
        t_pg_basic();
        t_assign();
        t_deglitch();
        t_blank();
        t_reset_mode();
        t_mode_change();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule